// File: doc/BRIEF.md
# Two-Stage Memory Attribute Combiner

This block takes the attribute descriptor produced by a first translation stage and the one produced by a second stage, and folds them into the single descriptor that the memory system acts on. Each descriptor carries a fault flag, a memory kind (Device or Normal), a two-bit device subtype, inner and outer cacheability codes with allocation hints, two shareability flags and a tag-capable flag. The second stage also supplies the physical address.

A mode input selects force-writeback combining. In that mode the second stage's inner cacheability code decides the result on its own: it can force write-back, inherit the first stage's setting, or downgrade to non-cacheable. Otherwise each cacheability level takes the weaker of the two stages. The merged descriptor is captured in an output register behind a valid/ready handshake, one result per accepted input.

Encodings: memory kind 0 = Device, 1 = Normal. Device subtype 00 nGnRnE, 01 nGnRE, 10 nGRE, 11 GRE, where a lower code is more restrictive. Cacheability 00 non-cacheable, 01 write-through, 10 write-back, 11 inherit. Hints are {read-allocate, write-allocate}, so 11 means allocate on both.

Top module: `xlat_attr_merge`

## Requirements
- R1: When `in_valid` and `in_ready` are both high at a clock edge, `out_valid` is high after that edge and the result of those inputs appears on the outputs. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R2: `out_addr` always equals the second-stage address of the accepted input, including when a fault is reported.
- R3: If either stage faults, `out_fault` is 1 and every other attribute output is copied from the first stage if the first stage faulted, and from the second stage if it did not.
- R4: Without a fault, the result is Device (`out_normal`=0) when the second stage is Device. It is also Device when the first stage is Device, except in force-writeback mode with a second-stage inner code of 10, where the result is Normal.
- R5: For a Device result, if the first stage is Normal the subtype comes from the second stage. If the second stage is Normal it comes from the first stage. If both are Device, the result is the lower of the two subtype codes.
- R6: A Device result has all cacheability and hint outputs at 00, both shareable flags at 1, and the tag flag at 0.
- R7: In force-writeback mode with a Normal result, a second-stage inner code of 10 gives inner code 10 with hints 11. A code of 11 copies the first stage's inner code and hints. Any other code gives 00 with hints 00. The outer code and hints equal the inner ones.
- R8: Without force-writeback and with a Normal result, the inner level and the outer level are each merged on their own. A code of 11 ranks as 10, and the lower rank wins, with its hints taken from the stage that supplied it. On a tie the first stage supplies the hints.
- R9: For a Normal result, `out_sh` is the OR of the two shareable flags, and `out_osh` is the OR of the two outer-shareable flags.
- R10: For a Normal result, `out_tag` is 1 exactly when the first stage is tagged and the final inner and outer codes are both 10 with hints 11.
- R11: A Normal, fault-free result reports device subtype 00.
- R12: After reset, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwb_mode | input | 1 | Force-writeback combining select |
| in_valid | input | 1 | Input descriptors valid |
| in_ready | output | 1 | Block can accept input |
| s1_fault | input | 1 | First-stage fault |
| s1_normal | input | 1 | First-stage memory kind |
| s1_dev | input | 2 | First-stage device subtype |
| s1_iattr | input | 2 | First-stage inner cacheability |
| s1_ihint | input | 2 | First-stage inner hints |
| s1_oattr | input | 2 | First-stage outer cacheability |
| s1_ohint | input | 2 | First-stage outer hints |
| s1_sh | input | 1 | First-stage shareable |
| s1_osh | input | 1 | First-stage outer shareable |
| s1_tag | input | 1 | First-stage tag-capable |
| s2_fault | input | 1 | Second-stage fault |
| s2_normal | input | 1 | Second-stage memory kind |
| s2_dev | input | 2 | Second-stage device subtype |
| s2_iattr | input | 2 | Second-stage inner cacheability |
| s2_ihint | input | 2 | Second-stage inner hints |
| s2_oattr | input | 2 | Second-stage outer cacheability |
| s2_ohint | input | 2 | Second-stage outer hints |
| s2_sh | input | 1 | Second-stage shareable |
| s2_osh | input | 1 | Second-stage outer shareable |
| s2_tag | input | 1 | Second-stage tag-capable |
| s2_addr | input | AW | Physical address from second stage |
| out_valid | output | 1 | Merged descriptor valid |
| out_ready | input | 1 | Consumer accepts merged descriptor |
| out_fault | output | 1 | Merged fault |
| out_normal | output | 1 | Merged memory kind |
| out_dev | output | 2 | Merged device subtype |
| out_iattr | output | 2 | Merged inner cacheability |
| out_ihint | output | 2 | Merged inner hints |
| out_oattr | output | 2 | Merged outer cacheability |
| out_ohint | output | 2 | Merged outer hints |
| out_sh | output | 1 | Merged shareable |
| out_osh | output | 1 | Merged outer shareable |
| out_tag | output | 1 | Merged tag-capable |
| out_addr | output | AW | Physical address |

## Verification
The bench builds the block with an address width of 36 instead of the default, so an address that is not a multiple of eight bits is carried through both the fault and non-fault paths. Every attribute field is two bits or one bit wide, so random stimulus reaches every code combination, including the inherit code on either stage and both modes. A bias toward tagged, write-back, allocate-all first stages makes the tag path reachable. Random `out_ready` stalls exercise holding and back-to-back acceptance.

// File: rtl/xam_pkg.sv
package xam_pkg;
  localparam int NLVL = 2;  // inner, outer
  localparam logic [1:0] CA_NC  = 2'b00;
  localparam logic [1:0] CA_WT  = 2'b01;
  localparam logic [1:0] CA_WB  = 2'b10;
  localparam logic [1:0] CA_INH = 2'b11;
  localparam logic [1:0] HINT_NONE = 2'b00;
  localparam logic [1:0] HINT_ALL  = 2'b11;

  typedef struct packed {
    logic       fault;
    logic       normal;
    logic [1:0] dev;
    logic [1:0] iattr;
    logic [1:0] ihint;
    logic [1:0] oattr;
    logic [1:0] ohint;
    logic       sh;
    logic       osh;
    logic       tag;
  } mattr_t;
endpackage

// File: rtl/xam_cache_merge.sv
// Weakest-wins merge of one cacheability level (non-force-writeback mode).
module xam_cache_merge
  import xam_pkg::*;
(
  input  logic [1:0] a_attr,
  input  logic [1:0] a_hint,
  input  logic [1:0] b_attr,
  input  logic [1:0] b_hint,
  output logic [1:0] attr,
  output logic [1:0] hint
);
  function automatic logic [1:0] rank(input logic [1:0] c);
    return (c == CA_INH) ? CA_WB : c;
  endfunction

  logic [1:0] ra, rb;
  assign ra = rank(a_attr);
  assign rb = rank(b_attr);

  always_comb begin
    if (rb < ra) begin
      attr = rb;
      hint = b_hint;
    end else begin
      attr = ra;
      hint = a_hint;
    end
  end
endmodule

// File: rtl/xam_fwb_select.sv
// Force-writeback: second-stage inner code decides the final cacheability.
module xam_fwb_select
  import xam_pkg::*;
(
  input  logic [1:0] s2_code,
  input  logic [1:0] s1_attr,
  input  logic [1:0] s1_hint,
  output logic [1:0] attr,
  output logic [1:0] hint
);
  always_comb begin
    unique case (s2_code)
      CA_WB:   begin attr = CA_WB;   hint = HINT_ALL;  end
      CA_INH:  begin attr = s1_attr; hint = s1_hint;   end
      default: begin attr = CA_NC;   hint = HINT_NONE; end
    endcase
  end
endmodule

// File: rtl/xam_dev_merge.sv
// Device subtype selection; lower code is more restrictive.
module xam_dev_merge (
  input  logic       a_normal,
  input  logic       b_normal,
  input  logic [1:0] a_dev,
  input  logic [1:0] b_dev,
  output logic [1:0] dev
);
  always_comb begin
    if (a_normal)      dev = b_dev;
    else if (b_normal) dev = a_dev;
    else               dev = (a_dev < b_dev) ? a_dev : b_dev;
  end
endmodule

// File: rtl/xam_out_stage.sv
// Single output register with valid/ready.
module xam_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] q
);
  logic load;
  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst)            out_valid <= 1'b0;
    else if (load)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end
endmodule

// File: rtl/xlat_attr_merge.sv
module xlat_attr_merge
  import xam_pkg::*;
#(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwb_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          s1_fault,
  input  logic          s1_normal,
  input  logic [1:0]    s1_dev,
  input  logic [1:0]    s1_iattr,
  input  logic [1:0]    s1_ihint,
  input  logic [1:0]    s1_oattr,
  input  logic [1:0]    s1_ohint,
  input  logic          s1_sh,
  input  logic          s1_osh,
  input  logic          s1_tag,
  input  logic          s2_fault,
  input  logic          s2_normal,
  input  logic [1:0]    s2_dev,
  input  logic [1:0]    s2_iattr,
  input  logic [1:0]    s2_ihint,
  input  logic [1:0]    s2_oattr,
  input  logic [1:0]    s2_ohint,
  input  logic          s2_sh,
  input  logic          s2_osh,
  input  logic          s2_tag,
  input  logic [AW-1:0] s2_addr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_fault,
  output logic          out_normal,
  output logic [1:0]    out_dev,
  output logic [1:0]    out_iattr,
  output logic [1:0]    out_ihint,
  output logic [1:0]    out_oattr,
  output logic [1:0]    out_ohint,
  output logic          out_sh,
  output logic          out_osh,
  output logic          out_tag,
  output logic [AW-1:0] out_addr
);
  localparam int MW = $bits(mattr_t);
  localparam int DW = MW + AW;

  mattr_t a, b, merged, q_attr;
  assign a = '{fault: s1_fault, normal: s1_normal, dev: s1_dev, iattr: s1_iattr,
               ihint: s1_ihint, oattr: s1_oattr, ohint: s1_ohint,
               sh: s1_sh, osh: s1_osh, tag: s1_tag};
  assign b = '{fault: s2_fault, normal: s2_normal, dev: s2_dev, iattr: s2_iattr,
               ihint: s2_ihint, oattr: s2_oattr, ohint: s2_ohint,
               sh: s2_sh, osh: s2_osh, tag: s2_tag};

  // Per-level weakest-wins merge
  logic [1:0] a_at [NLVL];
  logic [1:0] a_ht [NLVL];
  logic [1:0] b_at [NLVL];
  logic [1:0] b_ht [NLVL];
  logic [1:0] m_at [NLVL];
  logic [1:0] m_ht [NLVL];
  assign a_at[0] = a.iattr;  assign a_ht[0] = a.ihint;
  assign a_at[1] = a.oattr;  assign a_ht[1] = a.ohint;
  assign b_at[0] = b.iattr;  assign b_ht[0] = b.ihint;
  assign b_at[1] = b.oattr;  assign b_ht[1] = b.ohint;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    xam_cache_merge u_cm (
      .a_attr(a_at[g]), .a_hint(a_ht[g]),
      .b_attr(b_at[g]), .b_hint(b_ht[g]),
      .attr(m_at[g]),   .hint(m_ht[g])
    );
  end

  logic [1:0] f_at, f_ht;
  xam_fwb_select u_fwb (
    .s2_code(b.iattr), .s1_attr(a.iattr), .s1_hint(a.ihint),
    .attr(f_at), .hint(f_ht)
  );

  logic [1:0] dev_sel;
  xam_dev_merge u_dev (
    .a_normal(a.normal), .b_normal(b.normal),
    .a_dev(a.dev), .b_dev(b.dev), .dev(dev_sel)
  );

  logic any_fault, to_device;
  assign any_fault = a.fault || b.fault;
  assign to_device = !b.normal ||
                     (!a.normal && (!fwb_mode || (b.iattr != CA_WB)));

  always_comb begin
    merged = '0;
    if (any_fault) begin
      merged       = a.fault ? a : b;
      merged.fault = 1'b1;
    end else if (to_device) begin
      merged.normal = 1'b0;
      merged.dev    = dev_sel;
      merged.sh     = 1'b1;
      merged.osh    = 1'b1;
    end else begin
      merged.normal = 1'b1;
      if (fwb_mode) begin
        merged.iattr = f_at;     merged.ihint = f_ht;
        merged.oattr = f_at;     merged.ohint = f_ht;
      end else begin
        merged.iattr = m_at[0];  merged.ihint = m_ht[0];
        merged.oattr = m_at[1];  merged.ohint = m_ht[1];
      end
      merged.sh  = a.sh  || b.sh;
      merged.osh = a.osh || b.osh;
      merged.tag = a.tag && (merged.iattr == CA_WB) && (merged.ihint == HINT_ALL) &&
                   (merged.oattr == CA_WB) && (merged.ohint == HINT_ALL);
    end
  end

  logic [DW-1:0] q;
  xam_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .d({merged, s2_addr}),
    .out_valid(out_valid), .out_ready(out_ready),
    .q(q)
  );

  assign q_attr     = q[DW-1:AW];
  assign out_addr   = q[AW-1:0];
  assign out_fault  = q_attr.fault;
  assign out_normal = q_attr.normal;
  assign out_dev    = q_attr.dev;
  assign out_iattr  = q_attr.iattr;
  assign out_ihint  = q_attr.ihint;
  assign out_oattr  = q_attr.oattr;
  assign out_ohint  = q_attr.ohint;
  assign out_sh     = q_attr.sh;
  assign out_osh    = q_attr.osh;
  assign out_tag    = q_attr.tag;
endmodule

// File: rtl/xlat_attr_merge_chk.sv
module xlat_attr_merge_chk #(
  parameter int AW = 40
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic          s1_fault,
  input logic          s2_fault,
  input logic [AW-1:0] s2_addr,
  input logic          out_fault,
  input logic          out_normal,
  input logic [1:0]    out_dev,
  input logic [1:0]    out_iattr,
  input logic [1:0]    out_ihint,
  input logic [1:0]    out_oattr,
  input logic [1:0]    out_ohint,
  input logic          out_sh,
  input logic          out_osh,
  input logic          out_tag,
  input logic [AW-1:0] out_addr
);
  p_reset_r12: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  p_hold_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid &&
      $stable({out_fault, out_normal, out_dev, out_iattr, out_ihint, out_oattr,
               out_ohint, out_sh, out_osh, out_tag, out_addr}));

  p_addr_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_addr == $past(s2_addr));

  p_fault_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && (s1_fault || s2_fault) |=> out_fault);

  p_dev_plain_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_fault && !out_normal |->
      !out_tag && out_sh && out_osh && out_iattr == 2'b00 && out_oattr == 2'b00);

  p_tag_wb_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_fault && out_tag |->
      out_iattr == 2'b10 && out_ihint == 2'b11 && out_oattr == 2'b10 && out_ohint == 2'b11);

  p_normal_dev_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_fault && out_normal |-> out_dev == 2'b00);
endmodule

bind xlat_attr_merge xlat_attr_merge_chk #(.AW(AW)) u_chk (.*);

// File: tb/xlat_attr_merge_bench.sv
`timescale 1ns/1ps
module xlat_attr_merge_bench;
  import xam_pkg::*;
  localparam int AW = 36;
  localparam real HALF = 2.5;
  localparam int NCYC = 6000;

  logic clk = 0;
  always #(HALF) clk = ~clk;

  logic rst, fwb_mode, in_valid, in_ready, out_valid, out_ready;
  mattr_t s1, s2, got;
  logic [AW-1:0] s2_addr, out_addr;
  logic o_fault, o_normal, o_sh, o_osh, o_tag;
  logic [1:0] o_dev, o_iattr, o_ihint, o_oattr, o_ohint;

  int checks = 0, fails = 0;
  bit done = 0;

  xlat_attr_merge #(.AW(AW)) u_xlat_attr_merge (
    .clk(clk), .rst(rst), .fwb_mode(fwb_mode), .in_valid(in_valid), .in_ready(in_ready),
    .s1_fault(s1.fault), .s1_normal(s1.normal), .s1_dev(s1.dev), .s1_iattr(s1.iattr),
    .s1_ihint(s1.ihint), .s1_oattr(s1.oattr), .s1_ohint(s1.ohint), .s1_sh(s1.sh),
    .s1_osh(s1.osh), .s1_tag(s1.tag),
    .s2_fault(s2.fault), .s2_normal(s2.normal), .s2_dev(s2.dev), .s2_iattr(s2.iattr),
    .s2_ihint(s2.ihint), .s2_oattr(s2.oattr), .s2_ohint(s2.ohint), .s2_sh(s2.sh),
    .s2_osh(s2.osh), .s2_tag(s2.tag), .s2_addr(s2_addr),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_fault(o_fault), .out_normal(o_normal), .out_dev(o_dev), .out_iattr(o_iattr),
    .out_ihint(o_ihint), .out_oattr(o_oattr), .out_ohint(o_ohint), .out_sh(o_sh),
    .out_osh(o_osh), .out_tag(o_tag), .out_addr(out_addr)
  );

  assign got = '{fault: o_fault, normal: o_normal, dev: o_dev, iattr: o_iattr,
                 ihint: o_ihint, oattr: o_oattr, ohint: o_ohint,
                 sh: o_sh, osh: o_osh, tag: o_tag};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference, written from the requirements
  function automatic mattr_t model(input mattr_t a, input mattr_t b, input bit fwb);
    mattr_t r;
    int ra, rb;
    bit dev_res;
    r = '0;
    if (a.fault || b.fault) begin           // R3
      r = a.fault ? a : b;
      r.fault = 1;
      return r;
    end
    dev_res = (b.normal == 0) || (a.normal == 0 && (!fwb || b.iattr != 2));
    if (dev_res) begin
      if (a.normal)      r.dev = b.dev;
      else if (b.normal) r.dev = a.dev;
      else               r.dev = (a.dev < b.dev) ? a.dev : b.dev;
      r.sh = 1; r.osh = 1;
      return r;
    end
    r.normal = 1;
    if (fwb) begin
      if (b.iattr == 2)      begin r.iattr = 2; r.ihint = 3; end
      else if (b.iattr == 3) begin r.iattr = a.iattr; r.ihint = a.ihint; end
      r.oattr = r.iattr; r.ohint = r.ihint;
    end else begin
      ra = (a.iattr == 3) ? 2 : int'(a.iattr);
      rb = (b.iattr == 3) ? 2 : int'(b.iattr);
      if (rb < ra) begin r.iattr = 2'(rb); r.ihint = b.ihint; end
      else         begin r.iattr = 2'(ra); r.ihint = a.ihint; end
      ra = (a.oattr == 3) ? 2 : int'(a.oattr);
      rb = (b.oattr == 3) ? 2 : int'(b.oattr);
      if (rb < ra) begin r.oattr = 2'(rb); r.ohint = b.ohint; end
      else         begin r.oattr = 2'(ra); r.ohint = a.ohint; end
    end
    r.sh  = a.sh | b.sh;
    r.osh = a.osh | b.osh;
    r.tag = a.tag && r.iattr == 2 && r.ihint == 3 && r.oattr == 2 && r.ohint == 3;
    return r;
  endfunction

  function automatic mattr_t pick();
    logic [31:0] t;
    mattr_t m;
    t = $urandom;
    m = t[$bits(mattr_t)-1:0];
    m.fault = ($urandom % 8 == 0);
    return m;
  endfunction

  initial begin
    #(2.0 * HALF * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    mattr_t exp_d;
    logic [AW-1:0] exp_a;
    bit exp_v, exp_fwb;
    logic [63:0] t64;
    string ra, rs;

    rst = 1; fwb_mode = 0; in_valid = 0; out_ready = 0;
    s1 = '0; s2 = '0; s2_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R12 out_valid after reset", 64'(out_valid), 64'd0);
    chk("R1 in_ready after reset", 64'(in_ready), 64'd1);
    exp_v = 0; exp_d = '0; exp_a = '0; exp_fwb = 0;

    for (int c = 0; c < NCYC; c++) begin
      // compare against model state
      chk("R1 out_valid", 64'(out_valid), 64'(exp_v));
      if (exp_v) begin
        ra = exp_d.fault ? "R3" : (!exp_d.normal ? "R6" : (exp_fwb ? "R7" : "R8"));
        rs = exp_d.fault ? "R3" : (exp_d.normal ? "R9" : "R6");
        chk("R2 address", 64'(out_addr), 64'(exp_a));
        chk("R3 fault", 64'(got.fault), 64'(exp_d.fault));
        chk(exp_d.fault ? "R3 kind" : "R4 kind", 64'(got.normal), 64'(exp_d.normal));
        chk(exp_d.fault ? "R3 dev" : (exp_d.normal ? "R11 dev" : "R5 dev"),
            64'(got.dev), 64'(exp_d.dev));
        chk({ra, " inner/outer cacheability"},
            64'({got.iattr, got.ihint, got.oattr, got.ohint}),
            64'({exp_d.iattr, exp_d.ihint, exp_d.oattr, exp_d.ohint}));
        chk({rs, " shareability"}, 64'({got.sh, got.osh}), 64'({exp_d.sh, exp_d.osh}));
        chk(exp_d.fault ? "R3 tag" : "R10 tag", 64'(got.tag), 64'(exp_d.tag));
      end

      // new stimulus
      s1 = pick(); s2 = pick();
      if ($urandom % 2 == 0) begin
        s1.iattr = 2; s1.ihint = 3; s1.oattr = 2; s1.ohint = 3; s1.tag = 1;
        s2.iattr[1] = 1'b1; s2.oattr[1] = 1'b1; s2.ihint = 3; s2.ohint = 3;
      end
      t64 = {$urandom, $urandom};
      s2_addr = t64[AW-1:0];
      fwb_mode = $urandom % 2;
      in_valid = ($urandom % 4 != 0);
      out_ready = (c > 20 && c < 40) ? 1'b0 : ($urandom % 4 != 0);
      #1;
      chk("R1 in_ready", 64'(in_ready), 64'(!exp_v || out_ready));

      // advance model
      if (in_valid && (!exp_v || out_ready)) begin
        exp_d = model(s1, s2, fwb_mode);
        exp_a = s2_addr;
        exp_fwb = fwb_mode;
        exp_v = 1;
      end else if (out_ready) begin
        exp_v = 0;
      end
      @(posedge clk);
      @(negedge clk);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule